// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with PWM and Capture Channels

This block is a general-purpose up-counting timer for a peripheral subsystem. A divider stage turns the system clock into count ticks, one tick per `PSC+1` enabled clocks. A 16-bit main counter steps on each tick from zero up to a reload limit. On the tick after it reaches the limit, it wraps to zero and raises an update event. The update event sets a status flag. It can also drive the interrupt line and a one-cycle DMA request. The period in clocks is therefore `(PSC+1)*(ARR+1)`. For example, a divider setting of 83 with a limit of 999 on an 84 MHz clock gives a 1 kHz update rate.

Each of the `NCH` channels works in one of two modes:
- **PWM mode:** the channel output is high while the counter is below the channel's compare value.
- **Capture mode:** the channel copies the live counter value into its compare register when a chosen edge appears on its input. Before edge detection, the input passes through a two-flop synchronizer.

Software reaches the block through a plain single-cycle register port. A write is accepted in any cycle in which `reg_wr` is high. There is no flow control, so nothing is ever stalled or back-pressured. Reads are combinational from `reg_addr`.

While the timer runs, writes to the divider, limit and compare values land in hidden preload copies. These copies are transferred to the working registers only at the next update event. While the timer is stopped, these writes take effect at once.

Register map (word addresses):
- 0: control. Bit 0 is the run enable.
- 1: divider. Reads return the working value.
- 2: limit. Reads return the working value.
- 3: status, write 1 to clear:
  - bit 0: update flag
  - bit 1+c: capture flag of channel c
  - bit 1+NCH+c: overcapture flag of channel c
- 4: interrupt and DMA enables:
  - bit 0: update interrupt
  - bit 1: DMA request on update
  - bit 2+c: capture and overcapture interrupt of channel c
- 5: channel setup, 3 bits per channel at bits [3c+2:3c]:
  - bit 3c: mode, 0 = PWM, 1 = capture
  - bits [3c+2:3c+1]: edge select, 00 none, 01 rising, 10 falling, 11 both
- 6: live counter, read only.
- 8+c: compare value of channel c. Reads return the working value.

Top module: `tmr_top`

## Requirements
- R1: While enabled, the counter advances once every PSC+1 clocks, so successive update events are exactly (PSC+1)*(ARR+1) clocks apart.
- R2: The counter runs 0,1,…,ARR and then returns to 0 on the next tick. That wrap sets status bit 0. When enable bit 1 is set, the wrap also drives `dma_req` high for the single cycle after the wrap edge.
- R3: `irq` is high exactly when a set status flag has its enable bit set: bit 0 for the update flag, bit 2+c for the channel c flags.
- R4: A PWM-mode channel output is high while counter < compare value and low otherwise. A compare value of 0 never drives it high, and a compare value above ARR keeps it high for the whole period. A capture-mode channel drives its output low.
- R5: While enabled, divider, limit and compare writes change the value read back only at the next update event. While disabled, such writes take effect immediately.
- R6: A capture-mode channel loads the counter value into its compare register on the edges its edge field selects (01 rising, 10 falling, 11 both, 00 none). An edge that is not selected leaves the register unchanged.
- R7: A capture sets the channel's capture flag. When that flag is already set, the capture also sets the channel's overcapture flag.
- R8: A change on a capture input is reflected in the status register after three rising clock edges, and not after two.
- R9: With the enable bit clear, the counter and the divider stage hold their values.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| cap_in | input | NCH | Asynchronous capture inputs, one per channel |
| pwm_out | output | NCH | Channel waveform outputs |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | One-cycle DMA request on update |

## Verification
The bench builds the block with its defaults: four channels and 16-bit registers. Every status and setup field therefore fits inside one register word, and channel 1 can be driven as a capture channel while channel 0 produces PWM. A table of small divider and limit settings keeps each period to a few dozen clocks. This lets whole periods be measured edge to edge, including a limit of zero and compare values of zero, equal to ARR+1, and above ARR. A limit of 999 leaves room to stop the counter at distinct known values, so each captured value can be predicted exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_ARR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CFG  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP0 = 4'd8;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // 3-bit per-channel setup: [2:1] edge select, [0] capture mode
  typedef struct packed {
    edge_sel_e edge_sel;
    logic      cap_mode;
  } ch_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] psc,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = en && (pcnt >= psc);

  always_ff @(posedge clk) begin
    if (!rst_n)      pcnt <= '0;
    else if (en) begin
      if (pcnt >= psc) pcnt <= '0;
      else             pcnt <= pcnt + 1'b1;
    end
  end

  // R1
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));

  // R9
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pcnt));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] arr,
  output logic [W-1:0] cnt,
  output logic         upd
);
  // >= so that a limit lowered while stopped still wraps cleanly
  assign upd = en && tick && (cnt >= arr);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (en && tick) begin
      if (cnt >= arr)      cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == '0));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ch_cfg_t      cfg,
  input  logic [W-1:0] cnt,
  input  logic         upd,
  input  logic         running,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cap_in,
  output logic [W-1:0] cmp_act,
  output logic         pwm,
  output logic         cap_evt
);
  logic [W-1:0] cmp_pre;
  logic         sync1, sync2, sync_d;
  logic         rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync1  <= cap_in;
      sync2  <= sync1;
      sync_d <= sync2;
    end
  end

  assign rise    = sync2 & ~sync_d;
  assign fall    = ~sync2 & sync_d;
  assign cap_evt = cfg.cap_mode &&
                   ((cfg.edge_sel[0] && rise) || (cfg.edge_sel[1] && fall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pre <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_wr) cmp_pre <= cmp_wdata;
      if (cap_evt)
        cmp_act <= cnt;
      else if (!cfg.cap_mode && (upd || !running))
        cmp_act <= cmp_wr ? cmp_wdata : cmp_pre;
    end
  end

  assign pwm = !cfg.cap_mode && (cnt < cmp_act);

  // R6
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cmp_act == $past(cnt)));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq,
  output logic              dma_req
);
  localparam int unsigned CAP0  = 1;
  localparam int unsigned OVF0  = 1 + NCH;
  localparam int unsigned ST_W  = 1 + 2 * NCH;
  localparam int unsigned CFG_W = 3 * NCH;
  localparam int unsigned IEN_W = 2 + NCH;

  logic             en;
  logic [W-1:0]     psc_pre, psc_act, arr_pre, arr_act;
  logic [IEN_W-1:0] ien;
  logic [CFG_W-1:0] cfg_r;
  logic [ST_W-1:0]  stat, st_set, st_clr;
  logic             tick, upd;
  logic [W-1:0]     cnt;
  logic [NCH-1:0]   cap_evt;
  logic [W-1:0]     cmp_act [NCH];

  logic wr_ctrl, wr_psc, wr_arr, wr_stat, wr_ien, wr_cfg;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_psc  = reg_wr && (reg_addr == A_PSC);
  assign wr_arr  = reg_wr && (reg_addr == A_ARR);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      psc_pre <= '0;
      psc_act <= '0;
      arr_pre <= '0;
      arr_act <= '0;
      ien     <= '0;
      cfg_r   <= '0;
    end else begin
      if (wr_ctrl) en      <= reg_wdata[0];
      if (wr_psc)  psc_pre <= reg_wdata;
      if (wr_arr)  arr_pre <= reg_wdata;
      if (wr_ien)  ien     <= reg_wdata[IEN_W-1:0];
      if (wr_cfg)  cfg_r   <= reg_wdata[CFG_W-1:0];
      if (upd || !en) begin
        psc_act <= wr_psc ? reg_wdata : psc_pre;
        arr_act <= wr_arr ? reg_wdata : arr_pre;
      end
    end
  end

  tmr_prescaler #(.W(W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(en), .psc(psc_act), .tick(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .arr(arr_act),
    .cnt(cnt), .upd(upd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (ch_cfg_t'(cfg_r[3*c +: 3])),
      .cnt      (cnt),
      .upd      (upd),
      .running  (en),
      .cmp_wr   (reg_wr && (reg_addr == A_CMP0 + ADDR_W'(c))),
      .cmp_wdata(reg_wdata),
      .cap_in   (cap_in[c]),
      .cmp_act  (cmp_act[c]),
      .pwm      (pwm_out[c]),
      .cap_evt  (cap_evt[c])
    );
  end

  always_comb begin
    st_clr = wr_stat ? reg_wdata[ST_W-1:0] : '0;
    st_set = '0;
    st_set[0] = upd;
    for (int c = 0; c < NCH; c++) begin
      st_set[CAP0+c] = cap_evt[c];
      st_set[OVF0+c] = cap_evt[c] && stat[CAP0+c] && !st_clr[CAP0+c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '0;
      dma_req <= 1'b0;
    end else begin
      stat    <= (stat & ~st_clr) | st_set;
      dma_req <= upd && ien[1];
    end
  end

  assign irq = (stat[0] && ien[0])
             | (|(stat[CAP0 +: NCH] & ien[2 +: NCH]))
             | (|(stat[OVF0 +: NCH] & ien[2 +: NCH]));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[0]         = en;
      A_PSC:  reg_rdata            = psc_act;
      A_ARR:  reg_rdata            = arr_act;
      A_STAT: reg_rdata[ST_W-1:0]  = stat;
      A_IEN:  reg_rdata[IEN_W-1:0] = ien;
      A_CFG:  reg_rdata[CFG_W-1:0] = cfg_r;
      A_CNT:  reg_rdata            = cnt;
      default: begin
        for (int c = 0; c < NCH; c++)
          if (reg_addr == A_CMP0 + ADDR_W'(c)) reg_rdata = cmp_act[c];
      end
    endcase
  end

  // R2
  upd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> stat[0]);

  // R10
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !upd) |=> !stat[0]);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt[c] && stat[CAP0+c] && !(wr_stat && reg_wdata[CAP0+c]))
        |=> stat[OVF0+c]);
  end
endmodule

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  localparam int NCH = 4;
  localparam int W   = 16;
  localparam int NV  = 7;
  // {divider, limit, compare0}
  localparam int VEC [NV][3] = '{
    '{0, 3, 2}, '{1, 4, 7}, '{2, 5, 0}, '{3, 7, 4},
    '{0, 9, 10}, '{4, 2, 1}, '{1, 0, 1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [W-1:0]   reg_wdata = '0;
  logic [W-1:0]   reg_rdata;
  logic [NCH-1:0] cap_in = '0;
  logic [NCH-1:0] pwm_out;
  logic           irq, dma_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_top #(.NCH(NCH), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_dma();
    for (int i = 0; i < 2000; i++) begin
      if (dma_req) break;
      @(negedge clk);
    end
  endtask

  task automatic snap_count(input int run, output int v);
    wr(4'd0, 1);
    repeat (run) @(negedge clk);
    wr(4'd0, 0);
    rd(4'd6, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, x, y, z, n, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd0, v); check("R9 reset ctrl", v, 0);
    rd(4'd1, v); check("R5 reset divider", v, 0);
    rd(4'd2, v); check("R5 reset limit", v, 0);
    rd(4'd3, v); check("R10 reset status", v, 0);
    rd(4'd6, v); check("R2 reset count", v, 0);
    check("R4 reset pwm", int'(pwm_out), 0);
    check("R3 reset irq", int'(irq), 0);
    check("R2 reset dma", int'(dma_req), 0);

    // table of period / duty vectors on channel 0
    for (int i = 0; i < NV; i++) begin
      int p, a, c, ep, eh;
      p = VEC[i][0]; a = VEC[i][1]; c = VEC[i][2];
      ep = (p + 1) * (a + 1);
      eh = (p + 1) * ((c < a + 1) ? c : a + 1);
      wr(4'd0, 0);
      wr(4'd5, 0);
      wr(4'd1, p);
      wr(4'd2, a);
      wr(4'd8, c);
      wr(4'd4, 2);
      wr(4'd3, 'h1FF);
      wr(4'd0, 1);
      wait_dma();
      n = 0; h = 0;
      do begin
        if (pwm_out[0]) h++;
        n++;
        @(negedge clk);
      end while (!dma_req && n < 5000);
      check("R1 R2 period", n, ep);
      check("R4 high time", h, eh);
    end

    // R5: shadowed limit and compare while running
    wr(4'd0, 0);
    wr(4'd1, 0);
    wr(4'd2, 99);
    wr(4'd8, 1);
    wr(4'd0, 1);
    wr(4'd2, 9);
    wr(4'd8, 5);
    rd(4'd2, v); check("R5 limit held before update", v, 99);
    rd(4'd8, v); check("R5 compare held before update", v, 1);
    wait_dma();
    @(negedge clk);
    rd(4'd2, v); check("R5 limit after update", v, 9);
    rd(4'd8, v); check("R5 compare after update", v, 5);

    // R3 / R10: update flag, interrupt, write-one-to-clear
    wr(4'd4, 1);
    repeat (12) @(negedge clk);
    rd(4'd3, v); check("R2 update flag", v & 1, 1);
    check("R3 irq on update", int'(irq), 1);
    wr(4'd0, 0);
    wr(4'd3, 0);
    rd(4'd3, v); check("R10 write 0 keeps flag", v & 1, 1);
    wr(4'd3, 1);
    rd(4'd3, v); check("R10 write 1 clears flag", v & 1, 0);
    check("R3 irq drops", int'(irq), 0);

    // R9: stopped counter holds
    rd(4'd6, x);
    repeat (20) @(negedge clk);
    rd(4'd6, v); check("R9 count held", v, x);

    // capture on channel 1
    wr(4'd4, 0);
    wr(4'd1, 0);
    wr(4'd2, 999);
    wr(4'd5, 'h18);  // ch1: capture, rising only
    snap_count(37, x);
    cap_in[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(4'd3, v); check("R8 not yet after two edges", (v >> 2) & 1, 0);
    @(negedge clk);
    rd(4'd3, v); check("R8 flag after three edges", (v >> 2) & 1, 1);
    rd(4'd9, v); check("R6 rising capture value", v, x);
    check("R4 capture channel low", int'(pwm_out[1]), 0);

    snap_count(50, y);
    cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd9, v); check("R6 falling edge ignored", v, x);
    rd(4'd3, v); check("R7 no overcapture", (v >> 6) & 1, 0);

    wr(4'd3, 'h1FF);
    wr(4'd5, 'h38);  // ch1: capture, both edges
    cap_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd9, v); check("R6 both-edge rising capture", v, y);
    rd(4'd3, v); check("R7 capture flag", (v >> 2) & 1, 1);
    check("R7 no overcapture yet", (v >> 6) & 1, 0);

    snap_count(50, z);
    cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd9, v); check("R6 both-edge falling capture", v, z);
    rd(4'd3, v); check("R7 overcapture flag", (v >> 6) & 1, 1);
    check("R3 irq low with mask clear", int'(irq), 0);
    wr(4'd4, 'h8);
    check("R3 irq from channel 1", int'(irq), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule